// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This block forms the 32-bit effective address of one load or store. The memory is byte-addressed and little-endian, and one address space holds both code and data. On each valid request the block takes a base register, an offset register with a small left shift, a signed 32-bit immediate, the global pointer, two modify registers, a circular-buffer start value and a mode code. One clock later it presents the address for the memory port. For modes that update a register, it also presents the value to write back and a write enable.

The modes cover fixed addresses, with or without an update of the address register. Register-plus-shifted-register and immediate-plus-shifted-register forms are included, as are pointer-relative and base-relative forms. Post-increment comes in three flavours: linear, circular-buffer and bit-reversed. Every sum wraps modulo 2^32 and no overflow is reported.

Top module: `addr_gen_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are all zero: `out_valid`, `wb_en`, `ea` and `wb_data`.
- R2: The outputs are registered with one cycle of latency. `out_valid` equals `in_valid` from the previous edge. When `in_valid` is low, the next cycle has `out_valid` and `wb_en` low.
- R3: Mode 0 (fixed) gives `ea = imm`. Mode 1 (fixed with update) gives `ea = imm` and `wb_data = imm`.
- R4: Mode 2 gives `ea = imm + (ofs << sh_amt)`. Mode 6 gives `ea = base + (ofs << sh_amt)`. `sh_amt` is 0 to 3.
- R5: Mode 3 gives `ea = gp + imm`. Mode 4 gives `ea = base`. Mode 5 gives `ea = base + imm`, with `imm` taken as signed.
- R6: Mode 7 gives `ea = base` and `wb_data = base + imm`. Mode 8 gives `ea = base` and `wb_data = base + M`, where M is the selected modify register.
- R7: Modes 9 (immediate step) and 10 (register step) give `ea = base`. The buffer length L is M[16:0], and the mode-10 step is M[31:17] sign-extended. With S = `cstart` and n = base + step, `wb_data` is n − L when n ≥ S+L, n + L when n < S, and n otherwise.
- R8: Mode 11 gives `ea = {base[31:16], base[15:0] bit-reversed}`, so bit 0 goes to bit 15, and `wb_data = base + M`.
- R9: `wb_en` is high only for modes 1, 7, 8, 9, 10 and 11. For modes 0, 2–6 and the unused codes 12–15 it is low, and the unused codes give `ea = base`.
- R10: All address sums wrap modulo 2^32.
- R11: `msel` = 0 selects `mod0` and `msel` = 1 selects `mod1` as M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| base | input | 32 | Base address register value |
| ofs | input | 32 | Offset register value |
| sh_amt | input | 2 | Left shift applied to `ofs` |
| imm | input | 32 | Signed immediate |
| gp | input | 32 | Global pointer |
| mod0 | input | 32 | Modify register 0 |
| mod1 | input | 32 | Modify register 1 |
| msel | input | 1 | Modify register select |
| cstart | input | 32 | Circular buffer start |
| out_valid | output | 1 | Result present |
| ea | output | 32 | Effective address |
| wb_data | output | 32 | Value to write to the address register |
| wb_en | output | 1 | Address register write enable |

## Verification
The only state in this block is the output register, so a wrong internal value appears at the ports one cycle after the request that caused it. A mode decoded to the wrong arm shows up in that same cycle as a wrong `ea` or a wrong `wb_en`. A faulty circular correction or bit reversal shows up only on requests that hit a wrap edge or have asymmetric low bits. For that reason the directed cases land on both ends of the buffer and use bit patterns that are not palindromes.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int AGU_AW = 32;

    typedef enum logic [3:0] {
        MD_FIX      = 4'd0,
        MD_FIX_SET  = 4'd1,
        MD_FIX_ROFS = 4'd2,
        MD_GP_REL   = 4'd3,
        MD_IND      = 4'd4,
        MD_IND_IMM  = 4'd5,
        MD_IND_ROFS = 4'd6,
        MD_PINC_IMM = 4'd7,
        MD_PINC_MOD = 4'd8,
        MD_CIRC_IMM = 4'd9,
        MD_CIRC_MOD = 4'd10,
        MD_BREV     = 4'd11
    } agu_mode_e;

    typedef struct packed {
        logic [AGU_AW-1:0] ea;
        logic [AGU_AW-1:0] wb_data;
        logic              wb_en;
    } agu_result_t;

    function automatic logic mode_writes_back(input logic [3:0] m);
        return (m == MD_FIX_SET) || (m == MD_PINC_IMM) || (m == MD_PINC_MOD) ||
               (m == MD_CIRC_IMM) || (m == MD_CIRC_MOD) || (m == MD_BREV);
    endfunction

endpackage

// File: rtl/agu_mod_select.sv
module agu_mod_select
    import agu_pkg::*;
#(
    parameter int AW    = AGU_AW,
    parameter int LEN_W = 17
) (
    input  logic [AW-1:0] mod0,
    input  logic [AW-1:0] mod1,
    input  logic          msel,
    output logic [AW-1:0] mod_val,
    output logic [AW-1:0] circ_len,
    output logic [AW-1:0] circ_step
);
    localparam int STEP_W = AW - LEN_W;

    always_comb begin
        mod_val   = msel ? mod1 : mod0;
        circ_len  = {{STEP_W{1'b0}}, mod_val[LEN_W-1:0]};
        circ_step = {{LEN_W{mod_val[AW-1]}}, mod_val[AW-1:LEN_W]};
    end
endmodule

// File: rtl/agu_circ_wrap.sv
module agu_circ_wrap
    import agu_pkg::*;
#(
    parameter int AW = AGU_AW
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] next_ptr
);
    logic [AW-1:0] raw;
    logic [AW-1:0] limit;

    always_comb begin
        raw   = ptr + step;
        limit = start + len;
        if (raw >= limit)      next_ptr = raw - len;
        else if (raw < start)  next_ptr = raw + len;
        else                   next_ptr = raw;
    end

    // R7: a pointer inside a non-empty buffer, stepped by less than its length, stays inside
    always_comb begin
        if (len != '0 && limit > start && ptr >= start && ptr < limit &&
            $signed(step) < $signed(len) && $signed(step) > -$signed(len)) begin
            p_circ_range_r7: assert (next_ptr >= start && next_ptr < limit);
        end
    end
endmodule

// File: rtl/agu_ea_mux.sv
module agu_ea_mux
    import agu_pkg::*;
#(
    parameter int AW     = AGU_AW,
    parameter int SH_W   = 2,
    parameter int REV_W  = 16
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] ofs,
    input  logic [SH_W-1:0] sh_amt,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] gp,
    input  logic [AW-1:0] mod_val,
    input  logic [AW-1:0] circ_step,
    input  logic [AW-1:0] circ_next_imm,
    input  logic [AW-1:0] circ_next_mod,
    output agu_result_t   res
);
    logic [AW-1:0]    scaled;
    logic [REV_W-1:0] rev_low;

    genvar gi;
    generate
        for (gi = 0; gi < REV_W; gi++) begin : g_rev
            assign rev_low[gi] = base[REV_W-1-gi];
        end
    endgenerate

    assign scaled = ofs << sh_amt;

    always_comb begin
        res.ea      = base;
        res.wb_data = base;
        res.wb_en   = mode_writes_back(mode);
        unique case (mode)
            MD_FIX:      res.ea = imm;
            MD_FIX_SET:  begin res.ea = imm; res.wb_data = imm; end
            MD_FIX_ROFS: res.ea = imm + scaled;
            MD_GP_REL:   res.ea = gp + imm;
            MD_IND:      res.ea = base;
            MD_IND_IMM:  res.ea = base + imm;
            MD_IND_ROFS: res.ea = base + scaled;
            MD_PINC_IMM: res.wb_data = base + imm;
            MD_PINC_MOD: res.wb_data = base + mod_val;
            MD_CIRC_IMM: res.wb_data = circ_next_imm;
            MD_CIRC_MOD: res.wb_data = circ_next_mod;
            MD_BREV: begin
                res.ea      = {base[AW-1:REV_W], rev_low};
                res.wb_data = base + mod_val;
            end
            default: res.ea = base;
        endcase
    end

    // circ_step is consumed by the wrap unit; keep the input observed here for width checks
    logic unused_step;
    assign unused_step = ^circ_step;
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int LEN_W = 17,
    parameter int SH_W  = 2,
    parameter int REV_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [3:0]          mode,
    input  logic [AGU_AW-1:0]   base,
    input  logic [AGU_AW-1:0]   ofs,
    input  logic [SH_W-1:0]     sh_amt,
    input  logic [AGU_AW-1:0]   imm,
    input  logic [AGU_AW-1:0]   gp,
    input  logic [AGU_AW-1:0]   mod0,
    input  logic [AGU_AW-1:0]   mod1,
    input  logic                msel,
    input  logic [AGU_AW-1:0]   cstart,
    output logic                out_valid,
    output logic [AGU_AW-1:0]   ea,
    output logic [AGU_AW-1:0]   wb_data,
    output logic                wb_en
);
    localparam int AW = AGU_AW;

    logic [AW-1:0] mod_val, circ_len, circ_step;
    logic [AW-1:0] circ_next_imm, circ_next_mod;
    agu_result_t   comb_res;

    agu_mod_select #(.AW(AW), .LEN_W(LEN_W)) u_msel (
        .mod0(mod0), .mod1(mod1), .msel(msel),
        .mod_val(mod_val), .circ_len(circ_len), .circ_step(circ_step)
    );

    agu_circ_wrap #(.AW(AW)) u_wrap_imm (
        .ptr(base), .step(imm), .start(cstart), .len(circ_len),
        .next_ptr(circ_next_imm)
    );

    agu_circ_wrap #(.AW(AW)) u_wrap_mod (
        .ptr(base), .step(circ_step), .start(cstart), .len(circ_len),
        .next_ptr(circ_next_mod)
    );

    agu_ea_mux #(.AW(AW), .SH_W(SH_W), .REV_W(REV_W)) u_mux (
        .mode(mode), .base(base), .ofs(ofs), .sh_amt(sh_amt), .imm(imm),
        .gp(gp), .mod_val(mod_val), .circ_step(circ_step),
        .circ_next_imm(circ_next_imm), .circ_next_mod(circ_next_mod),
        .res(comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ea        <= '0;
            wb_data   <= '0;
            wb_en     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= in_valid & comb_res.wb_en;
            if (in_valid) begin
                ea      <= comb_res.ea;
                wb_data <= comb_res.wb_data;
            end
        end
    end

    p_lat_on_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_lat_off_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wb_en));
    p_no_wb_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mode == 4'd0 || (mode >= 4'd2 && mode <= 4'd6) || mode >= 4'd12))
        |=> !wb_en);
    p_post_ea_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mode == 4'd7 || mode == 4'd8)) |=> (ea == $past(base) && wb_en));
    p_brev_hi_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 4'd11) |=> (ea[AW-1:REV_W] == $past(base[AW-1:REV_W])));
endmodule

// File: tb/addr_gen_unit_tb.sv
module addr_gen_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [31:0] base = '0, ofs = '0, imm = '0, gp = '0;
    logic [31:0] mod0 = '0, mod1 = '0, cstart = '0;
    logic [1:0]  sh_amt = '0;
    logic        msel = 1'b0;
    logic        out_valid, wb_en;
    logic [31:0] ea, wb_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    addr_gen_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base(base),
        .ofs(ofs), .sh_amt(sh_amt), .imm(imm), .gp(gp), .mod0(mod0), .mod1(mod1),
        .msel(msel), .cstart(cstart), .out_valid(out_valid), .ea(ea),
        .wb_data(wb_data), .wb_en(wb_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request; outputs are read at the negedge after the capturing posedge
    task automatic issue(input logic [3:0] m);
        @(negedge clk);
        mode = m;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 wb_en", {31'd0, wb_en}, 32'd0);
        chk("R1 ea", ea, 32'd0);
        chk("R1 wb_data", wb_data, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_fixed;
        imm = 32'h1234_5678;
        issue(4'd0);
        chk("R3 fixed ea", ea, 32'h1234_5678);
        chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
        chk("R9 fixed wb_en", {31'd0, wb_en}, 32'd0);
        imm = 32'hDEAD_BEEF;
        issue(4'd1);
        chk("R3 set ea", ea, 32'hDEAD_BEEF);
        chk("R3 set wb_data", wb_data, 32'hDEAD_BEEF);
        chk("R9 set wb_en", {31'd0, wb_en}, 32'd1);
    endtask

    task automatic t_scaled;
        imm = 32'h0000_1000; ofs = 32'h10; sh_amt = 2'd3;
        issue(4'd2);
        chk("R4 imm+ofs<<3", ea, 32'h0000_1080);
        base = 32'h2000_0000; ofs = 32'h5; sh_amt = 2'd2;
        issue(4'd6);
        chk("R4 base+ofs<<2", ea, 32'h2000_0014);
        sh_amt = 2'd0;
        issue(4'd6);
        chk("R4 base+ofs<<0", ea, 32'h2000_0005);
        chk("R9 scaled wb_en", {31'd0, wb_en}, 32'd0);
    endtask

    task automatic t_simple;
        gp = 32'h8000; imm = 32'd200;
        issue(4'd3);
        chk("R5 gp rel", ea, 32'h0000_80C8);
        base = 32'hA5A5_0000;
        issue(4'd4);
        chk("R5 indirect", ea, 32'hA5A5_0000);
        base = 32'h100; imm = 32'hFFFF_FFFC;
        issue(4'd5);
        chk("R5 base-4", ea, 32'h0000_00FC);
    endtask

    task automatic t_postinc;
        base = 32'h3000; imm = 32'd8;
        issue(4'd7);
        chk("R6 pinc imm ea", ea, 32'h3000);
        chk("R6 pinc imm wb", wb_data, 32'h3008);
        mod0 = 32'h4; mod1 = 32'h40; msel = 1'b1;
        issue(4'd8);
        chk("R11 msel1 wb", wb_data, 32'h3040);
        chk("R6 pinc mod ea", ea, 32'h3000);
        msel = 1'b0;
        issue(4'd8);
        chk("R11 msel0 wb", wb_data, 32'h3004);
        chk("R9 pinc wb_en", {31'd0, wb_en}, 32'd1);
    endtask

    task automatic t_circ;
        cstart = 32'h1000; mod0 = 32'h40; msel = 1'b0;
        base = 32'h1038; imm = 32'd8;
        issue(4'd9);
        chk("R7 upper wrap", wb_data, 32'h1000);
        chk("R7 circ ea", ea, 32'h1038);
        base = 32'h1004; imm = 32'hFFFF_FFF8;
        issue(4'd9);
        chk("R7 lower wrap", wb_data, 32'h103C);
        base = 32'h1010; imm = 32'd4;
        issue(4'd9);
        chk("R7 no wrap", wb_data, 32'h1014);
        mod1 = 32'h0018_0040; msel = 1'b1; base = 32'h103C;
        issue(4'd10);
        chk("R7 mod step +12", wb_data, 32'h1008);
        mod1 = 32'hFFF8_0040; base = 32'h1000;
        issue(4'd10);
        chk("R7 mod step -4", wb_data, 32'h103C);
        chk("R9 circ wb_en", {31'd0, wb_en}, 32'd1);
    endtask

    task automatic t_brev;
        msel = 1'b0; mod0 = 32'h0000_0800;
        base = 32'h1234_0001;
        issue(4'd11);
        chk("R8 brev ea", ea, 32'h1234_8000);
        chk("R8 brev wb", wb_data, 32'h1234_0801);
        base = 32'hABCD_00F0;
        issue(4'd11);
        chk("R8 brev nibble", ea, 32'hABCD_0F00);
    endtask

    task automatic t_unused;
        base = 32'h0000_0777;
        issue(4'd13);
        chk("R9 unused ea", ea, 32'h0000_0777);
        chk("R9 unused wb_en", {31'd0, wb_en}, 32'd0);
    endtask

    task automatic t_wrap32;
        base = 32'hFFFF_FFF0; imm = 32'h20;
        issue(4'd5);
        chk("R10 ea wrap", ea, 32'h0000_0010);
        issue(4'd7);
        chk("R10 wb wrap", wb_data, 32'h0000_0010);
    endtask

    task automatic t_idle;
        imm = 32'h1; base = 32'h1;
        issue(4'd1);
        @(negedge clk);
        chk("R2 idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R2 idle wb_en", {31'd0, wb_en}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset;
        t_fixed;
        t_scaled;
        t_simple;
        t_postinc;
        t_circ;
        t_brev;
        t_unused;
        t_wrap32;
        t_idle;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule